// File: doc/BRIEF.md
# In-Place Byte Array Smoother

This engine walks a byte array that sits inside a 64-byte frame memory and replaces each element with the mean of itself and the next element, writing the results back over the originals. The frame header tells the engine where the array begins and how many elements it has. The engine fetches that header first, then visits the elements in ascending order. Because of that order, the right-hand neighbour of each element is always read before it is overwritten.

A single mode input, sampled together with `start`, chooses one of two modes:
- **Linear mode:** the final element is left alone.
- **Circular mode:** the final element is averaged with the value that element 0 held before the pass began.

The frame memory sits outside the block. The engine reaches it through one word-wide port:
- The port holds 16 words of 32 bits.
- Reads return data one clock after they are issued.
- Writes carry a byte-lane mask, so each result touches exactly one byte.

A host pulses `start`, waits for the one-cycle `done`, and may cancel a pass at any time with `abort`.

Top module: `array_smoother`

## Requirements
- R1: Byte k of the frame lives in word k/4, lane k%4 (lane 0 = bits 7:0). The start offset is read from byte 4 (word 1, lane 0) and the element count N from byte 5 (word 1, lane 1). Element i sits at byte address (start + i) mod 64.
- R2: With `wrapSel`=0, elements 0..N-2 each become floor((a[i] + a[i+1]) / 2). This uses the values present before the pass and 9-bit unsigned addition. Element N-1 keeps its value.
- R3: With `wrapSel`=1, elements 0..N-2 are updated as in R2. Element N-1 becomes floor((a[N-1] + original a[0]) / 2).
- R4: When N is 0, or N is 1 in linear mode, the pass ends with no memory write. When N is 1 in circular mode, exactly one write occurs, and it stores the element's own value back.
- R5: Every write enables exactly one byte lane, and the result byte is copied to all four lanes of `memWrData`. A read and a write never share a cycle, and every write follows a read in the previous cycle.
- R6: `done` is high for exactly one cycle. It rises 3 + 3*M clock edges after the edge that samples `start`, where M is the number of elements written.
- R7: A `start` pulse that arrives while `busy` is high has no effect on the result, the write count or the number of `done` pulses.
- R8: `abort` lowers `busy` at the next clock edge. No write occurs in the abort cycle or afterwards, no `done` follows, and bytes written earlier in the pass keep their new values.
- R9: During and after reset, `busy`, `done`, `memRdEn` and `memWrEn` are low. While `busy` is low, no memory access is issued.
- R10: An array that runs past byte 63 wraps to byte 0. The pass still ends with `done` and the timing given in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a pass when the engine is idle |
| wrapSel | input | 1 | Mode sampled with start: 1 = circular, 0 = linear |
| abort | input | 1 | Cancels the pass and returns to idle |
| busy | output | 1 | High from the cycle after start until the engine is idle again |
| done | output | 1 | One-cycle pulse at the end of a completed pass |
| memAddr | output | 4 | Word address for a read or write |
| memRdEn | output | 1 | Read request; data is returned on memRdData one cycle later |
| memRdData | input | 32 | Read data from the frame memory |
| memWrEn | output | 1 | Write request |
| memWrData | output | 32 | Result byte copied to every lane |
| memByteEn | output | 4 | Lane enables for the write |

## Verification
The assertions check the port rules on every cycle:
- A write enables one lane and carries the same byte in every lane.
- A read and a write never share a cycle, and a write always follows a read.
- After an abort, the engine is idle by the next cycle and writes nothing in the abort cycle.
- `done` lasts a single cycle, and an idle engine stays off the memory.

Only the bench scenarios can show the rest:
- the averaged values in both modes, with their end-element rules;
- the exact latency as a function of the element count;
- the short-length cases;
- the wrap past the top of memory;
- that a repeated `start` is ignored and that an aborted pass leaves exactly the already-written prefix.

// File: rtl/smooth_pkg.sv
package smooth_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_HCAP, S_EVAL, S_RDA, S_RDB, S_WR, S_DONE
  } smState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldArg;   // latch mode bit
    logic rdHdr;   // read header word
    logic ldHdr;   // capture start offset and count
    logic clrIdx;  // zero element index
    logic rdA;     // read word holding element i
    logic rdB;     // read word holding element i+1, capture element i
    logic capA;    // capture element i byte
    logic wrEl;    // write averaged byte
    logic incIdx;  // advance element index
  } smCtl_t;

endpackage

// File: rtl/smooth_ctrl.sv
module smooth_ctrl
  import smooth_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   abort,
  input  logic   lenNone,
  input  logic   isLast,
  output smCtl_t ctl,
  output logic   busy,
  output logic   done
);

  smState_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.ldArg = 1'b1;
        nxt = S_HDR;
      end
      S_HDR: begin
        ctl.rdHdr = 1'b1;
        nxt = S_HCAP;
      end
      S_HCAP: begin
        ctl.ldHdr  = 1'b1;
        ctl.clrIdx = 1'b1;
        nxt = S_EVAL;
      end
      S_EVAL: nxt = lenNone ? S_DONE : S_RDA;
      S_RDA: begin
        ctl.rdA = 1'b1;
        nxt = S_RDB;
      end
      S_RDB: begin
        ctl.rdB  = 1'b1;
        ctl.capA = 1'b1;
        nxt = S_WR;
      end
      S_WR: begin
        ctl.wrEl = 1'b1;
        if (isLast) nxt = S_DONE;
        else begin
          ctl.incIdx = 1'b1;
          nxt = S_RDA;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (abort) begin
      ctl = '0;
      nxt = S_IDLE;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/smooth_dpath.sv
module smooth_dpath
  import smooth_pkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int DATA_W  = 32,
  parameter int DS_BYTE = 4,
  parameter int DL_BYTE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  smCtl_t            ctl,
  input  logic              wrapSel,
  input  logic [DATA_W-1:0] memRdData,
  output logic [WORD_AW-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic              lenNone,
  output logic              isLast
);

  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int BYTE_AW = WORD_AW + LANE_W;
  localparam int DS_LANE = DS_BYTE % LANES;
  localparam int DL_LANE = DL_BYTE % LANES;
  localparam logic [WORD_AW-1:0] HDR_WORD = WORD_AW'(DS_BYTE / LANES);

  logic               circ;
  logic [BYTE_AW-1:0] dsReg;
  logic [7:0]         dlReg;
  logic [7:0]         idx;
  logic [7:0]         aByte;
  logic [7:0]         orig0;

  logic [BYTE_AW-1:0] aAddr, bAddr;
  logic [LANE_W-1:0]  aLane, bLane;
  logic [7:0]         rdLaneA, rdLaneB, bByte, avg, lastIdx;
  logic [8:0]         sum;

  assign aAddr   = dsReg + idx[BYTE_AW-1:0];
  assign bAddr   = aAddr + 1'b1;
  assign aLane   = aAddr[LANE_W-1:0];
  assign bLane   = bAddr[LANE_W-1:0];
  assign rdLaneA = memRdData[int'(aLane)*8 +: 8];
  assign rdLaneB = memRdData[int'(bLane)*8 +: 8];

  assign lastIdx = circ ? (dlReg - 8'd1) : (dlReg - 8'd2);
  assign isLast  = (idx == lastIdx);
  assign lenNone = (dlReg == 8'd0) || ((dlReg == 8'd1) && !circ);

  // circular tail pairs with the saved original head
  assign bByte = (circ && isLast) ? orig0 : rdLaneB;
  assign sum   = {1'b0, aByte} + {1'b0, bByte};
  assign avg   = sum[8:1];

  always_comb begin
    if (ctl.rdHdr)     memAddr = HDR_WORD;
    else if (ctl.rdB)  memAddr = bAddr[BYTE_AW-1:LANE_W];
    else               memAddr = aAddr[BYTE_AW-1:LANE_W];
  end

  assign memRdEn   = ctl.rdHdr | ctl.rdA | ctl.rdB;
  assign memWrEn   = ctl.wrEl;
  assign memWrData = {LANES{avg}};

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign memByteEn[l] = ctl.wrEl && (aLane == LANE_W'(l));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      circ  <= 1'b0;
      dsReg <= '0;
      dlReg <= '0;
      idx   <= '0;
      aByte <= '0;
      orig0 <= '0;
    end else begin
      if (ctl.ldArg) circ <= wrapSel;
      if (ctl.ldHdr) begin
        dsReg <= memRdData[DS_LANE*8 +: BYTE_AW];
        dlReg <= memRdData[DL_LANE*8 +: 8];
      end
      if (ctl.clrIdx)      idx <= '0;
      else if (ctl.incIdx) idx <= idx + 8'd1;
      if (ctl.capA) begin
        aByte <= rdLaneA;
        if (idx == 8'd0) orig0 <= rdLaneA;
      end
    end
  end

endmodule

// File: rtl/array_smoother.sv
module array_smoother
  import smooth_pkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int DATA_W  = 32,
  parameter int DS_BYTE = 4,
  parameter int DL_BYTE = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                wrapSel,
  input  logic                abort,
  output logic                busy,
  output logic                done,
  output logic [WORD_AW-1:0]  memAddr,
  output logic                memRdEn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memWrEn,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memByteEn
);

  smCtl_t ctl;
  logic   lenNone, isLast;

  smooth_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .lenNone(lenNone), .isLast(isLast),
    .ctl(ctl), .busy(busy), .done(done)
  );

  smooth_dpath #(
    .WORD_AW(WORD_AW), .DATA_W(DATA_W), .DS_BYTE(DS_BYTE), .DL_BYTE(DL_BYTE)
  ) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .wrapSel(wrapSel),
    .memRdData(memRdData), .memAddr(memAddr), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memWrData(memWrData), .memByteEn(memByteEn),
    .lenNone(lenNone), .isLast(isLast)
  );

endmodule

// File: rtl/array_smoother_chk.sv
module array_smoother_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                abort,
  input logic                busy,
  input logic                done,
  input logic                memRdEn,
  input logic                memWrEn,
  input logic [DATA_W-1:0]   memWrData,
  input logic [DATA_W/8-1:0] memByteEn
);

  localparam int LANES = DATA_W / 8;

  p_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> $countones(memByteEn) == 1);

  p_lane_copy_r5: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> memWrData == {LANES{memWrData[7:0]}});

  p_no_rdwr_r5: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> $past(memRdEn));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);

  p_abort_nowr_r8: assert property (@(posedge clk) disable iff (rst)
    abort |-> !memWrEn);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!memRdEn && !memWrEn && !done));

endmodule

bind array_smoother array_smoother_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .busy(busy), .done(done),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
  .memByteEn(memByteEn)
);

// File: tb/array_smoother_test.sv
module array_smoother_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wrapSel = 1'b0;
  logic        abort = 1'b0;
  logic        busy, done, memRdEn, memWrEn;
  logic [3:0]  memAddr;
  logic [31:0] memRdData, memWrData;
  logic [3:0]  memByteEn;

  logic [31:0] mem [16];
  logic [7:0]  img [64];
  int total = 0;
  int bad = 0;
  int wrCnt = 0;
  int doneCnt = 0;

  always #10 clk = ~clk;

  array_smoother uut (
    .clk(clk), .rst(rst), .start(start), .wrapSel(wrapSel), .abort(abort),
    .busy(busy), .done(done), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .memByteEn(memByteEn)
  );

  // frame memory model, one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memAddr];
    if (memWrEn) begin
      for (int l = 0; l < 4; l++)
        if (memByteEn[l]) mem[memAddr][l*8 +: 8] <= memWrData[l*8 +: 8];
      wrCnt <= wrCnt + 1;
    end
    if (done) doneCnt <= doneCnt + 1;
  end

  // {start offset, count, mode, seed}
  localparam logic [31:0] VEC [7] = '{
    {8'd12, 8'd8,  8'd0, 8'd3},   // R2 linear
    {8'd12, 8'd8,  8'd1, 8'd5},   // R3 circular
    {8'd20, 8'd2,  8'd0, 8'd7},   // R2 shortest linear
    {8'd30, 8'd33, 8'd1, 8'd9},   // R3 long circular
    {8'd12, 8'd51, 8'd1, 8'd11},  // R3 maximum length
    {8'd40, 8'd5,  8'd0, 8'd13},  // R2 mid frame
    {8'd60, 8'd8,  8'd1, 8'd15}   // R10 wrap past byte 63
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int ds, input int dl, input int seed);
    for (int k = 0; k < 64; k++) img[k] = 8'((k * seed * 37) + (seed * 11) + (k * k));
    img[4] = 8'(ds);
    img[5] = 8'(dl);
    for (int w = 0; w < 16; w++) mem[w] = {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]};
  endtask

  function automatic int elemCount(input int dl, input bit circ);
    if (circ) return dl;
    return (dl >= 2) ? dl - 1 : 0;
  endfunction

  // reference pass over img, applying at most lim element updates
  task automatic model(input int ds, input int dl, input bit circ, input int lim);
    int m;
    logic [7:0] o0, a, b;
    m = elemCount(dl, circ);
    o0 = 8'd0;
    for (int i = 0; i < m && i < lim; i++) begin
      a = img[(ds + i) & 63];
      if (i == 0) o0 = a;
      b = (circ && i == m - 1) ? o0 : img[(ds + i + 1) & 63];
      img[(ds + i) & 63] = 8'(({1'b0, a} + {1'b0, b}) >> 1);
    end
  endtask

  task automatic compareMem(input string req);
    int miss;
    int firstK;
    miss = 0;
    firstK = -1;
    for (int k = 0; k < 64; k++)
      if (mem[k/4][(k%4)*8 +: 8] !== img[k]) begin
        miss++;
        if (firstK < 0) firstK = k;
      end
    if (firstK >= 0)
      check(1'b0, req, int'(mem[firstK/4][(firstK%4)*8 +: 8]), int'(img[firstK]));
    else
      check(1'b1, req, 0, 0);
  endtask

  task automatic runPass(input int ds, input int dl, input bit circ, input string req);
    int lat;
    int m;
    int d0;
    m = elemCount(dl, circ);
    fill(ds, dl, ds + dl + 1);
    model(ds, dl, circ, 1000);
    wrCnt = 0;
    d0 = doneCnt;
    @(negedge clk);
    start = 1'b1;
    wrapSel = circ;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 2000);
    check(lat == 4 + 3 * m, {req, " latency"}, lat, 4 + 3 * m);
    @(negedge clk);
    check(wrCnt == m, {req, " writes"}, wrCnt, m);
    check(doneCnt - d0 == 1, {req, " done count"}, doneCnt - d0, 1);
    compareMem({req, " memory"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(busy == 1'b0, "R9 busy in reset", busy, 0);
    check(done == 1'b0 && memRdEn == 1'b0 && memWrEn == 1'b0, "R9 outputs in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && memRdEn == 1'b0, "R9 idle after reset", busy, 0);

    // table walk: R1 header read, R2/R3 values, R6 latency, R10 wrap
    for (int v = 0; v < 7; v++) begin
      logic [31:0] e;
      string tag;
      e = VEC[v];
      case (v)
        0, 2, 5: tag = "R2";
        1, 3, 4: tag = "R3";
        default: tag = "R10";
      endcase
      runPass(int'(e[31:24]), int'(e[23:16]), e[8], $sformatf("%s vec%0d", tag, v));
    end

    // R4 short lengths
    runPass(12, 0, 1'b0, "R4 count0 linear");
    runPass(12, 0, 1'b1, "R4 count0 circular");
    runPass(12, 1, 1'b0, "R4 count1 linear");
    runPass(16, 1, 1'b1, "R4 count1 circular");

    // R7 start while busy is ignored
    begin
      int d0;
      fill(14, 10, 21);
      model(14, 10, 1'b0, 1000);
      wrCnt = 0;
      d0 = doneCnt;
      @(negedge clk);
      start = 1'b1;
      wrapSel = 1'b0;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      start = 1'b1;
      wrapSel = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      check(busy == 1'b0, "R7 idle after pass", busy, 0);
      check(doneCnt - d0 == 1, "R7 done count", doneCnt - d0, 1);
      check(wrCnt == 9, "R7 writes", wrCnt, 9);
      compareMem("R7 memory");
    end

    // R8 abort mid pass
    begin
      int w0;
      int d0;
      fill(12, 40, 29);
      wrCnt = 0;
      d0 = doneCnt;
      @(negedge clk);
      start = 1'b1;
      wrapSel = 1'b0;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R8 busy after abort", busy, 0);
      abort = 1'b0;
      w0 = wrCnt;
      repeat (30) @(negedge clk);
      check(wrCnt == w0, "R8 no writes after abort", wrCnt, w0);
      check(doneCnt == d0, "R8 no done after abort", doneCnt - d0, 0);
      check(w0 > 0 && w0 < 39, "R8 partial prefix length", w0, 1);
      model(12, 40, 1'b0, w0);
      compareMem("R8 kept prefix");
    end

    // R9 engine still usable after abort
    runPass(24, 6, 1'b1, "R9 pass after abort");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule